// File: doc/BRIEF.md
# Transmit power ramp sequencer

This block drives the control code of a power-amplifier DAC around each transmit burst. A 64-word by 10-bit curve table is loaded through a plain write port while the block is idle. When the transmit-enable input rises, the sequencer waits a programmable number of clock cycles. It then plays the lower half of the table, which is the rising curve, and holds the last level for as long as transmit-enable stays high. When transmit-enable drops, it plays the upper half of the table, which is the falling curve, and returns to rest.

Every new code appears on a 10-bit output together with a one-cycle strobe. Steps are spaced by a fixed prescaler of `STEP_DIV` clock cycles. A mode input selects single-burst or double-burst operation. In double-burst mode, the first drop of transmit-enable does not start the falling curve. The output holds its level through the gap, and the falling curve runs only after the second burst has ended. At most two bursts can be linked this way.

Top module: `tx_ramp_sequencer`

## Requirements
- R1: A write with `wrEn` high while `busy` is low stores `wrData` at table address `wrAddr`. Later ramps play the stored value.
- R2: `busy` is high from the cycle after a rising edge of `txOn` is sampled in idle until the final falling-curve step. A table write issued while `busy` is high is ignored.
- R3: While idle, `rampCode` is 0 and `rampStrobe` is low. After reset `rampCode` is 0 and `rampStrobe` and `busy` are low.
- R4: If `txOn` is first sampled high at clock edge E, the first rising-curve code appears after edge E+`startDelay`+1. A `startDelay` of 0 gives the minimum latency.
- R5: The rising curve plays table addresses 0 to 31 in ascending order, one per `STEP_DIV` cycles. Each code is marked by a one-cycle `rampStrobe`.
- R6: After the rising curve, `rampCode` holds the entry at address 31 with no strobe while `txOn` stays high.
- R7: In single-burst mode (`doubleBurst` = 0), if `txOn` is sampled low at edge F during the hold, table addresses 32 to 63 are played ascending. The first code appears after edge F+1, and the rest follow one per `STEP_DIV` cycles.
- R8: In double-burst mode (`doubleBurst` = 1), the first drop of `txOn` keeps `busy` high and holds the level with no strobe. A new rise returns to the hold. The falling curve starts on the second drop, with the R7 timing.
- R9: `rampCode` returns to 0 one cycle after the last falling-curve step. A `txOn` that rises during the falling curve and stays high does not start a new ramp.
- R10: `rampStrobe` is never high in two consecutive cycles when `STEP_DIV` is greater than 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Table write enable |
| wrAddr | input | 6 | Table write address (0–31 rising, 32–63 falling) |
| wrData | input | 10 | Table write data |
| startDelay | input | 8 | Cycles from sampled rise of `txOn` to ramp start |
| doubleBurst | input | 1 | 1 = link two bursts, 0 = single burst |
| txOn | input | 1 | Transmit enable |
| rampCode | output | 10 | DAC control code |
| rampStrobe | output | 1 | One-cycle pulse when `rampCode` takes a new step |
| busy | output | 1 | Sequence in progress; table locked |

## Verification
Some rules are checked on every cycle by the assertions. Idle means a zero code with no strobe, and a strobe only appears while a ramp is running. Between strobes the code is stable, two strobes are never adjacent, and a locked table entry does not change when a write arrives. Other properties need a whole burst to be played end to end, so only the bench scenarios can show them. These are the exact value and cycle of every one of the 64 steps under several table patterns, the start latency for a sweep of delays, the gap bridging in double-burst mode, and the absence of a restart.

// File: rtl/ramp_seq_pkg.sv
package ramp_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_UP,
    ST_HOLD,
    ST_GAP,
    ST_DOWN
  } rampState_t;

  // strobes from sequencing control to the table/output datapath
  typedef struct packed {
    logic emit;      // load a new code this cycle
    logic downHalf;  // read the falling half of the table
    logic clearOut;  // force rest level
    logic lock;      // table writes blocked
  } rampStrobes_t;

endpackage

// File: rtl/ramp_seq_ctrl.sv
module ramp_seq_ctrl
  import ramp_seq_pkg::*;
#(
  parameter int DELAY_W  = 8,
  parameter int IDX_W    = 5,
  parameter int STEP_DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               txOn,
  input  logic               doubleBurst,
  input  logic [DELAY_W-1:0] startDelay,
  output rampStrobes_t       strobes,
  output logic [IDX_W-1:0]   stepIdx,
  output logic               busy
);

  localparam int PRE_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = {IDX_W{1'b1}};
  localparam logic [PRE_W-1:0] PRE_RELOAD = PRE_W'(STEP_DIV - 1);

  rampState_t         state;
  logic [DELAY_W-1:0] delayCnt;
  logic [PRE_W-1:0]   preCnt;
  logic               txOnQ;
  logic               secondBurst;
  logic               riseSeen;
  logic               stepTick;

  assign riseSeen = txOn & ~txOnQ;
  assign stepTick = ((state == ST_UP) || (state == ST_DOWN)) && (preCnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      delayCnt    <= '0;
      preCnt      <= '0;
      stepIdx     <= '0;
      txOnQ       <= 1'b0;
      secondBurst <= 1'b0;
    end else begin
      txOnQ <= txOn;
      case (state)
        ST_IDLE: begin
          secondBurst <= 1'b0;
          if (riseSeen) begin
            preCnt  <= '0;
            stepIdx <= '0;
            if (startDelay == '0) begin
              state <= ST_UP;
            end else begin
              delayCnt <= startDelay;
              state    <= ST_DELAY;
            end
          end
        end
        ST_DELAY: begin
          if (delayCnt == DELAY_W'(1)) state <= ST_UP;
          else delayCnt <= delayCnt - DELAY_W'(1);
        end
        ST_UP, ST_DOWN: begin
          if (preCnt == '0) begin
            preCnt  <= PRE_RELOAD;
            stepIdx <= stepIdx + IDX_W'(1);
            if (stepIdx == IDX_LAST) state <= (state == ST_UP) ? ST_HOLD : ST_IDLE;
          end else begin
            preCnt <= preCnt - PRE_W'(1);
          end
        end
        ST_HOLD: begin
          if (!txOn) begin
            preCnt  <= '0;
            stepIdx <= '0;
            state   <= (doubleBurst && !secondBurst) ? ST_GAP : ST_DOWN;
          end
        end
        ST_GAP: begin
          if (txOn) begin
            secondBurst <= 1'b1;
            state       <= ST_HOLD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy             = (state != ST_IDLE);
  assign strobes.emit     = stepTick;
  assign strobes.downHalf = (state == ST_DOWN);
  assign strobes.clearOut = (state == ST_IDLE);
  assign strobes.lock     = busy;

  // R4: a sampled rise in idle always starts a sequence
  p_rise_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && txOn && !txOnQ) |=> busy);

  // R4: the delay phase never sits on an exhausted counter
  p_delay_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DELAY) |-> (delayCnt != '0));

  // R8: the gap is only ever entered from the hold
  p_gap_from_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> ($past(state) == ST_HOLD || $past(state) == ST_GAP));

endmodule

// File: rtl/ramp_seq_datapath.sv
module ramp_seq_datapath
  import ramp_seq_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CODE_W-1:0] wrData,
  input  rampStrobes_t      strobes,
  input  logic [ADDR_W-2:0] stepIdx,
  output logic [CODE_W-1:0] rampCode,
  output logic              rampStrobe
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [CODE_W-1:0] curveTbl [DEPTH];
  logic [ADDR_W-1:0] rdAddr;
  logic              wrAccept;

  assign wrAccept = wrEn && !strobes.lock;
  assign rdAddr   = {strobes.downHalf, stepIdx};

  always_ff @(posedge clk) begin
    if (wrAccept) curveTbl[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rampCode   <= '0;
      rampStrobe <= 1'b0;
    end else begin
      rampStrobe <= strobes.emit;
      if (strobes.emit) rampCode <= curveTbl[rdAddr];
      else if (strobes.clearOut) rampCode <= '0;
    end
  end

  // R2: a write during a sequence leaves the addressed entry untouched
  p_locked_table_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.lock && wrEn) |=> (curveTbl[$past(wrAddr)] == $past(curveTbl[wrAddr])));

endmodule

// File: rtl/tx_ramp_sequencer.sv
module tx_ramp_sequencer
  import ramp_seq_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int ADDR_W   = 6,
  parameter int DELAY_W  = 8,
  parameter int STEP_DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [CODE_W-1:0]  wrData,
  input  logic [DELAY_W-1:0] startDelay,
  input  logic               doubleBurst,
  input  logic               txOn,
  output logic [CODE_W-1:0]  rampCode,
  output logic               rampStrobe,
  output logic               busy
);

  localparam int IDX_W = ADDR_W - 1;

  rampStrobes_t     strobes;
  logic [IDX_W-1:0] stepIdx;

  ramp_seq_ctrl #(
    .DELAY_W (DELAY_W),
    .IDX_W   (IDX_W),
    .STEP_DIV(STEP_DIV)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .txOn       (txOn),
    .doubleBurst(doubleBurst),
    .startDelay (startDelay),
    .strobes    (strobes),
    .stepIdx    (stepIdx),
    .busy       (busy)
  );

  ramp_seq_datapath #(
    .CODE_W(CODE_W),
    .ADDR_W(ADDR_W)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strobes   (strobes),
    .stepIdx   (stepIdx),
    .rampCode  (rampCode),
    .rampStrobe(rampStrobe)
  );

  // R3: a settled idle block rests at code 0 with no strobe
  p_idle_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> (rampCode == '0 && !rampStrobe));

  // R5: strobes only follow a cycle in which a sequence was running
  p_strobe_in_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rampStrobe |-> $past(busy));

  // R6: between strobes of a running sequence the code does not move
  p_quiet_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !rampStrobe) |-> $stable(rampCode));

  generate
    if (STEP_DIV > 1) begin : g_spacing
      // R10: steps are never back to back
      p_strobe_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rampStrobe |=> !rampStrobe);
    end
  endgenerate

endmodule

// File: tb/tx_ramp_sequencer_tb.sv
module tx_ramp_sequencer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int S          = 4;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [5:0] wrAddr = '0;
  logic [9:0] wrData = '0;
  logic [7:0] startDelay = '0;
  logic       doubleBurst = 1'b0;
  logic       txOn = 1'b0;
  logic [9:0] rampCode;
  logic       rampStrobe;
  logic       busy;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  int nSt = 0;
  int stCode [128];
  int stCyc [128];
  int curPat = 0;

  tx_ramp_sequencer #(.STEP_DIV(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .startDelay(startDelay), .doubleBurst(doubleBurst), .txOn(txOn),
    .rampCode(rampCode), .rampStrobe(rampStrobe), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && rampStrobe && nSt < 128) begin
      stCode[nSt] = int'(rampCode);
      stCyc[nSt]  = cyc;
      nSt++;
    end
  end

  function automatic int patVal(int p, int a);
    if (p == 0) return (a * 37 + 5) % 1024;
    if (p == 1) return 1023 - a * 13;
    return a * 16;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > WD_LIMIT) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WD_LIMIT);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeWord(input int a, input int v);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 6'(a); wrData = 10'(v);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadTable(input int p);
    for (int a = 0; a < 64; a++) writeWord(a, patVal(p, a));
    curPat = p;
  endtask

  task automatic runBurst(input int d, input bit dbl, input bit reRise);
    int riseN, fallN, bad;
    @(negedge clk);
    startDelay = 8'(d); doubleBurst = dbl; nSt = 0;
    @(negedge clk);
    txOn = 1'b1; riseN = cyc;
    @(negedge clk);
    check(busy == 1'b1, "R2 busy after rise", int'(busy), 1);
    // try to overwrite a falling-curve entry mid-sequence
    writeWord(40, 10'h155);
    while (cyc < riseN + d + 2 + 31 * S + 2) @(negedge clk);
    check(nSt == 32, "R5 rising step count", nSt, 32);
    check(stCyc[0] == riseN + d + 2, "R4 start latency", stCyc[0] - riseN, d + 2);
    bad = 0;
    for (int k = 0; k < 32; k++)
      if (stCode[k] != patVal(curPat, k) || stCyc[k] != riseN + d + 2 + k * S) bad++;
    check(bad == 0, "R5 rising values and spacing", bad, 0);
    bad = 0;
    for (int k = 1; k < 32; k++) if (stCyc[k] - stCyc[k-1] < 2) bad++;
    check(bad == 0, "R10 no adjacent strobes", bad, 0);
    repeat (10) @(negedge clk);
    check(nSt == 32 && int'(rampCode) == patVal(curPat, 31), "R6 hold level",
          int'(rampCode), patVal(curPat, 31));
    if (dbl) begin
      txOn = 1'b0;
      repeat (20) @(negedge clk);
      check(nSt == 32 && busy && int'(rampCode) == patVal(curPat, 31), "R8 gap holds level",
            int'(rampCode), patVal(curPat, 31));
      txOn = 1'b1;
      repeat (10) @(negedge clk);
      check(nSt == 32 && busy, "R8 second burst no ramp", nSt, 32);
    end
    txOn = 1'b0; fallN = cyc;
    if (reRise) begin
      repeat (20) @(negedge clk);
      txOn = 1'b1;
    end
    while (cyc < fallN + 2 + 31 * S) @(negedge clk);
    check(busy == 1'b0, "R9 busy drops at last step", int'(busy), 0);
    @(negedge clk);
    check(rampCode == 10'd0, "R9 rest after ramp-down", int'(rampCode), 0);
    check(nSt == 64, "R7 falling step count", nSt, 64);
    bad = 0;
    for (int k = 0; k < 32; k++)
      if (stCode[32+k] != patVal(curPat, 32 + k) || stCyc[32+k] != fallN + 2 + k * S) bad++;
    check(bad == 0, "R7 falling values and timing (R2 lock)", bad, 0);
    if (reRise) begin
      repeat (30) @(negedge clk);
      check(!busy && nSt == 64 && rampCode == 10'd0, "R9 no restart on held txOn",
            int'(busy), 0);
      txOn = 1'b0;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check(!busy && !rampStrobe && rampCode == 10'd0, "R3 idle rest", int'(rampCode), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rampCode == 10'd0 && !rampStrobe && !busy, "R3 reset state", int'(rampCode), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: table loaded while idle, verified by playback
    loadTable(0);
    runBurst(5, 1'b0, 1'b1);
    for (int d = 0; d < 5; d++) runBurst(d, 1'b0, 1'b0);
    loadTable(1);
    runBurst(9, 1'b1, 1'b0);
    loadTable(2);
    runBurst(255, 1'b1, 1'b1);
    runBurst(1, 1'b0, 1'b0);
    summary();
  end

endmodule